// File: doc/BRIEF.md
# Scatter-Gather DMA Channel Register Interface

This block is the register front end of a multi-channel scatter-gather DMA engine. A host drives word-sized register reads and writes over a simple strobe bus, and the block decodes them into a global area (address mode, interrupt status, interrupt pending, interrupt enable) and a per-channel area. Channels come in pairs. The even member of a pair receives and the odd member transmits, and both share one 64-byte register window. Each channel holds a descriptor list base address, a length and a block length. Each receive channel also holds a run enable and a bytes-per-row value. The block hands the descriptor base address to each channel's datapath, issues a one-cycle start pulse, and takes back a one-cycle done pulse.

Each channel runs a two-state controller. CH_IDLE moves to CH_BUSY on the "go" transition and emits the start pulse. For a transmit channel, "go" is a write of the descriptor low address. For a receive channel, "go" is a write of 1 to the enable bit. CH_BUSY returns to CH_IDLE on the "finish" transition, which is a done pulse, or on the "halt" transition, which is a write of 0 to a receive enable. A done pulse sets the channel's interrupt status bit. The single level interrupt output is the OR of the status bits that are also enabled.

Top module: `dmach_regif`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and every `ch_start` and `ch_busy` bit is low.
- R2: A write to the transmit descriptor low address (pair base + 0x1C) of an idle transmit channel drives that channel's `ch_start` high for exactly the one cycle after the write. The written value appears on that channel's slice of `ch_desc_addr`, and the channel becomes busy.
- R3: Writing a receive channel's descriptor low address (pair base + 0x04) does not start it. Writing 1 to bit 0 of its enable register (pair base + 0x14) starts it with a one-cycle `ch_start`, and the enable register then reads 1.
- R4: Writing 0 to a receive enable register returns the channel to idle, and the enable then reads 0. A done pulse returns any busy channel to idle.
- R5: Interrupt status is at 0x80000, with bit i for channel i. A done pulse sets the bit, and writing 1 to a bit clears it. When a done pulse and a clear of the same bit arrive in the same cycle, the bit stays set.
- R6: Interrupt enable is read/write at 0x80008. Pending at 0x80004 reads as status AND enable. `irq` is high exactly when any pending bit is set.
- R7: The descriptor high address (receive +0x00, transmit +0x18), length (receive +0x0C, transmit +0x2C), block length (receive +0x10, transmit +0x24) and receive bytes-per-row (+0x30) registers store and read back the written value. A high address write leaves `ch_desc_addr` unchanged.
- R8: Bit 0 of the address mode register at 0x34 is read/write and drives `addr32_mode`.
- R9: Reads of unmapped offsets return 0. This includes offset 0x34 of any pair other than pair 0, unused offsets inside a window, addresses beyond the last pair, and unused global addresses.
- R10: `reg_rdata` carries the read value in the cycle after `reg_rd_en` and holds it until the next read.
- R11: While a channel is busy, a further go write produces no new start pulse. For a transmit channel that write still updates the descriptor address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte address of the register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, registered |
| ch_done | input | NCH | Per-channel transfer-finished pulse |
| ch_start | output | NCH | Per-channel start pulse |
| ch_busy | output | NCH | Channel is in CH_BUSY |
| ch_desc_addr | output | NCH*DW | Descriptor list base address per channel |
| rx_row_bytes | output | NPAIR*DW | Bytes-per-row per receive channel |
| addr32_mode | output | 1 | 32-bit addressing selected |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, start pulses, busy changes and status updates all take effect at the clock edge that samples the strobe, so they are visible one cycle after the stimulus. `irq` follows status combinationally in that same cycle. Read data is due one cycle after the read strobe. The bench's monitor pops each expected read value exactly one cycle after the driver issued the read. Port checks are taken on the falling edge that follows the sampling rising edge, and each start pulse is checked both in its one cycle and in the cycle after it.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_e;

    // one-hot write selects for a single channel
    typedef struct packed {
        logic dhi;
        logic dlo;
        logic len;
        logic blen;
        logic en;
        logic row;
    } ch_sel_t;

    // offsets inside a 64-byte pair window
    localparam logic [5:0] OFF_RX_DHI  = 6'h00;
    localparam logic [5:0] OFF_RX_DLO  = 6'h04;
    localparam logic [5:0] OFF_RX_LEN  = 6'h0C;
    localparam logic [5:0] OFF_RX_BLEN = 6'h10;
    localparam logic [5:0] OFF_RX_EN   = 6'h14;
    localparam logic [5:0] OFF_TX_DHI  = 6'h18;
    localparam logic [5:0] OFF_TX_DLO  = 6'h1C;
    localparam logic [5:0] OFF_TX_BLEN = 6'h24;
    localparam logic [5:0] OFF_TX_LEN  = 6'h2C;
    localparam logic [5:0] OFF_RX_ROW  = 6'h30;

    // global registers
    localparam logic [31:0] ADR_MODE   = 32'h0000_0034;
    localparam logic [31:0] ADR_STAT   = 32'h0008_0000;
    localparam logic [31:0] ADR_PEND   = 32'h0008_0004;
    localparam logic [31:0] ADR_IRQEN  = 32'h0008_0008;

endpackage

// File: rtl/dmach_chan.sv
module dmach_chan
    import dmach_pkg::*;
#(
    parameter bit IS_RX = 1'b1,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ch_sel_t       wr_sel,
    input  logic [DW-1:0] wdata,
    input  logic          done,
    output logic          start,
    output logic          busy,
    output logic [DW-1:0] desc_lo,
    output logic [DW-1:0] desc_hi,
    output logic [DW-1:0] xfer_len,
    output logic [DW-1:0] blk_len,
    output logic [DW-1:0] row_bytes,
    output logic          run_bit
);

    ch_state_e state_q, state_d;
    logic      go, halt;

    generate
        if (IS_RX) begin : g_rx
            assign go   = wr_sel.en && wdata[0];
            assign halt = wr_sel.en && !wdata[0];
            always_ff @(posedge clk) begin
                if (!rst_n)          row_bytes <= '0;
                else if (wr_sel.row) row_bytes <= wdata;
            end
            assign run_bit = (state_q == CH_BUSY);
        end else begin : g_tx
            logic sel_unused;
            assign go         = wr_sel.dlo;
            assign halt       = 1'b0;
            assign row_bytes  = '0;
            assign run_bit    = 1'b0;
            assign sel_unused = wr_sel.en ^ wr_sel.row;
        end
    endgenerate

    // next-state: go / finish / halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (go)           state_d = CH_BUSY;
            CH_BUSY: if (halt || done) state_d = CH_IDLE;
            default:                   state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // outputs and stored fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start    <= 1'b0;
            desc_lo  <= '0;
            desc_hi  <= '0;
            xfer_len <= '0;
            blk_len  <= '0;
        end else begin
            start <= (state_q == CH_IDLE) && go;
            if (wr_sel.dlo)  desc_lo  <= wdata;
            if (wr_sel.dhi)  desc_hi  <= wdata;
            if (wr_sel.len)  xfer_len <= wdata;
            if (wr_sel.blen) blk_len  <= wdata;
        end
    end

    assign busy = (state_q == CH_BUSY);

endmodule

// File: rtl/dmach_irq.sv
module dmach_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] done,
    input  logic           stat_wr,
    input  logic           en_wr,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] stat_q,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] pend,
    output logic           irq
);

    logic [NCH-1:0] clr;

    assign clr = stat_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | done;   // set beats clear
            if (en_wr) en_q <= wdata;
        end
    end

    assign pend = stat_q & en_q;
    assign irq  = |pend;

endmodule

// File: rtl/dmach_regif.sv
module dmach_regif
    import dmach_pkg::*;
#(
    parameter int NPAIR = 2,
    parameter int AW    = 20,
    parameter int DW    = 32,
    parameter int NCH   = 2 * NPAIR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NCH-1:0]    ch_done,
    output logic [NCH-1:0]    ch_start,
    output logic [NCH-1:0]    ch_busy,
    output logic [NCH*DW-1:0] ch_desc_addr,
    output logic [NPAIR*DW-1:0] rx_row_bytes,
    output logic              addr32_mode,
    output logic              irq
);

    localparam int WIN_W = AW - 6;

    logic [5:0]       off;
    logic [NPAIR-1:0] pair_hit;
    logic [DW-1:0]    c_lo   [NCH];
    logic [DW-1:0]    c_hi   [NCH];
    logic [DW-1:0]    c_len  [NCH];
    logic [DW-1:0]    c_blen [NCH];
    logic [DW-1:0]    c_row  [NCH];
    logic [NCH-1:0]   c_run;
    logic [NCH-1:0]   irq_stat, irq_en_q, irq_pend;
    logic             wr_mode, wr_stat, wr_irqen;
    logic [DW-1:0]    rd_val;

    assign off = reg_addr[5:0];

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            assign pair_hit[p] = (reg_addr[AW-1:6] == WIN_W'(p));
        end

        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam int P  = c / 2;
            localparam bit RX = ((c % 2) == 0);
            ch_sel_t sel;

            always_comb begin
                sel = '0;
                if (reg_wr_en && pair_hit[P]) begin
                    if (RX) begin
                        sel.dhi  = (off == OFF_RX_DHI);
                        sel.dlo  = (off == OFF_RX_DLO);
                        sel.len  = (off == OFF_RX_LEN);
                        sel.blen = (off == OFF_RX_BLEN);
                        sel.en   = (off == OFF_RX_EN);
                        sel.row  = (off == OFF_RX_ROW);
                    end else begin
                        sel.dhi  = (off == OFF_TX_DHI);
                        sel.dlo  = (off == OFF_TX_DLO);
                        sel.len  = (off == OFF_TX_LEN);
                        sel.blen = (off == OFF_TX_BLEN);
                    end
                end
            end

            dmach_chan #(.IS_RX(RX), .DW(DW)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_sel    (sel),
                .wdata     (reg_wdata),
                .done      (ch_done[c]),
                .start     (ch_start[c]),
                .busy      (ch_busy[c]),
                .desc_lo   (c_lo[c]),
                .desc_hi   (c_hi[c]),
                .xfer_len  (c_len[c]),
                .blk_len   (c_blen[c]),
                .row_bytes (c_row[c]),
                .run_bit   (c_run[c])
            );

            assign ch_desc_addr[c*DW +: DW] = c_lo[c];
            if (RX) begin : g_row
                assign rx_row_bytes[P*DW +: DW] = c_row[c];
            end
        end
    endgenerate

    assign wr_mode  = reg_wr_en && (reg_addr == AW'(ADR_MODE));
    assign wr_stat  = reg_wr_en && (reg_addr == AW'(ADR_STAT));
    assign wr_irqen = reg_wr_en && (reg_addr == AW'(ADR_IRQEN));

    always_ff @(posedge clk) begin
        if (!rst_n)       addr32_mode <= 1'b0;
        else if (wr_mode) addr32_mode <= reg_wdata[0];
    end

    dmach_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (ch_done),
        .stat_wr (wr_stat),
        .en_wr   (wr_irqen),
        .wdata   (reg_wdata[NCH-1:0]),
        .stat_q  (irq_stat),
        .en_q    (irq_en_q),
        .pend    (irq_pend),
        .irq     (irq)
    );

    // read decode; global addresses override the window lookup
    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NPAIR; p++) begin
            if (pair_hit[p]) begin
                case (off)
                    OFF_RX_DHI:  rd_val = c_hi[2*p];
                    OFF_RX_DLO:  rd_val = c_lo[2*p];
                    OFF_RX_LEN:  rd_val = c_len[2*p];
                    OFF_RX_BLEN: rd_val = c_blen[2*p];
                    OFF_RX_EN:   rd_val = DW'(c_run[2*p]);
                    OFF_RX_ROW:  rd_val = c_row[2*p];
                    OFF_TX_DHI:  rd_val = c_hi[2*p+1];
                    OFF_TX_DLO:  rd_val = c_lo[2*p+1];
                    OFF_TX_BLEN: rd_val = c_blen[2*p+1];
                    OFF_TX_LEN:  rd_val = c_len[2*p+1];
                    default:     rd_val = '0;
                endcase
            end
        end
        if (reg_addr == AW'(ADR_MODE))  rd_val = DW'(addr32_mode);
        if (reg_addr == AW'(ADR_STAT))  rd_val = DW'(irq_stat);
        if (reg_addr == AW'(ADR_PEND))  rd_val = DW'(irq_pend);
        if (reg_addr == AW'(ADR_IRQEN)) rd_val = DW'(irq_en_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         reg_rdata <= '0;
        else if (reg_rd_en) reg_rdata <= rd_val;
    end

endmodule

// File: rtl/dmach_regif_chk.sv
module dmach_regif_chk #(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_wr_en,
    input logic           reg_rd_en,
    input logic [DW-1:0]  reg_rdata,
    input logic [NCH-1:0] ch_done,
    input logic [NCH-1:0] ch_start,
    input logic [NCH-1:0] ch_busy,
    input logic [NCH-1:0] stat,
    input logic [NCH-1:0] irq_en,
    input logic           irq
);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_a
            p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ch_start[i] |=> !ch_start[i]);
            p_start_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ch_start[i] |-> $past(reg_wr_en));
            p_busy_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ch_busy[i]) |-> ($past(ch_done[i]) || $past(reg_wr_en)));
            p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ch_done[i] |=> stat[i]);
        end
    endgenerate

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata));

endmodule

bind dmach_regif dmach_regif_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_rdata (reg_rdata),
    .ch_done   (ch_done),
    .ch_start  (ch_start),
    .ch_busy   (ch_busy),
    .stat      (irq_stat),
    .irq_en    (irq_en_q),
    .irq       (irq)
);

// File: tb/test_dmach_regif.sv
module test_dmach_regif;

    localparam int NPAIR = 2;
    localparam int NCH   = 4;
    localparam int AW    = 20;
    localparam int DW    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic [NCH-1:0]    done = '0;
    logic [NCH-1:0]    start, busy;
    logic [NCH*DW-1:0] desc;
    logic [NPAIR*DW-1:0] rowb;
    logic              a32, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } rd_item_t;
    rd_item_t sb_q[$];
    logic     rd_pend = 1'b0;

    always #10 clk = ~clk;

    dmach_regif #(.NPAIR(NPAIR), .AW(AW), .DW(DW)) i_dmach_regif (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .ch_done(done), .ch_start(start), .ch_busy(busy),
        .ch_desc_addr(desc), .rx_row_bytes(rowb), .addr32_mode(a32), .irq(irq)
    );

    function automatic void chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endfunction

    // monitor: read data due one cycle after the strobe
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (sb_q.size() == 0) chk("scoreboard empty", 0, 1);
            else begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk(it.tag, rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        sb_q.push_back('{exp: e, tag: tag});
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(negedge clk); done = m;
        @(negedge clk); done = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        chk("watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 start", DW'(start), 0);
        chk("R1 busy", DW'(busy), 0);
        chk("R1 irq", DW'(irq), 0);
        rd(20'h80000, 0, "R1 status");
        rd(20'h0001C, 0, "R1 tx dlo");

        // R2 transmit start on low address write
        wr(20'h0001C, 32'h1000_0040);
        chk("R2 start pulse", DW'(start), 4'b0010);
        chk("R2 desc addr", desc[1*DW +: DW], 32'h1000_0040);
        @(negedge clk);
        chk("R2 pulse one cycle", DW'(start), 0);
        chk("R2 busy", DW'(busy[1]), 1);

        // R11 no restart while busy
        wr(20'h0001C, 32'h0000_2000);
        chk("R11 no pulse", DW'(start), 0);
        chk("R11 addr updated", desc[1*DW +: DW], 32'h0000_2000);

        // R3 receive starts only on enable
        wr(20'h00044, 32'h0000_ABC0);
        chk("R3 dlo no start", DW'(start), 0);
        chk("R3 still idle", DW'(busy[2]), 0);
        wr(20'h00054, 32'h1);
        chk("R3 enable start", DW'(start), 4'b0100);
        rd(20'h00054, 1, "R3 enable reads 1");

        // R4 stop via enable 0
        wr(20'h00054, 32'h0);
        chk("R4 rx halted", DW'(busy[2]), 0);
        rd(20'h00054, 0, "R4 enable reads 0");

        // R5 / R6 interrupts
        wr(20'h80008, 32'h2);
        rd(20'h80008, 2, "R6 enable readback");
        pulse(4'b0010);
        chk("R6 irq high", DW'(irq), 1);
        chk("R4 done ends busy", DW'(busy[1]), 0);
        rd(20'h80000, 2, "R5 status set");
        rd(20'h80004, 2, "R6 pending");
        pulse(4'b1000);
        rd(20'h80000, 32'hA, "R5 status two bits");
        rd(20'h80004, 2, "R6 pending masked");
        wr(20'h80000, 32'h2);
        rd(20'h80000, 32'h8, "R5 w1c");
        chk("R6 irq low", DW'(irq), 0);
        @(negedge clk); done = 4'b1000; wr_en = 1'b1; addr = 20'h80000; wdata = 32'h8;
        @(negedge clk); done = '0; wr_en = 1'b0;
        rd(20'h80000, 32'h8, "R5 set beats clear");
        wr(20'h80000, 32'hFFFF_FFFF);
        rd(20'h80000, 0, "R5 clear all");

        // R7 stored fields
        wr(20'h0004C, 32'h100);
        wr(20'h00050, 32'h200);
        wr(20'h00070, 32'h280);
        wr(20'h00040, 32'h55);
        wr(20'h00018, 32'h77);
        wr(20'h0002C, 32'h33);
        wr(20'h00024, 32'h44);
        rd(20'h0004C, 32'h100, "R7 rx len");
        rd(20'h00050, 32'h200, "R7 rx blen");
        rd(20'h00070, 32'h280, "R7 rx row");
        rd(20'h00040, 32'h55, "R7 rx dhi");
        rd(20'h00018, 32'h77, "R7 tx dhi");
        rd(20'h0002C, 32'h33, "R7 tx len");
        rd(20'h00024, 32'h44, "R7 tx blen");
        chk("R7 row out", rowb[1*DW +: DW], 32'h280);
        chk("R7 dhi no effect rx", desc[2*DW +: DW], 32'h0000_ABC0);
        chk("R7 dhi no effect tx", desc[1*DW +: DW], 32'h0000_2000);

        // R8 address mode
        chk("R8 mode reset", DW'(a32), 0);
        wr(20'h00034, 32'h1);
        chk("R8 mode out", DW'(a32), 1);
        rd(20'h00034, 1, "R8 mode read");

        // R9 unmapped
        rd(20'h00008, 0, "R9 hole in window");
        rd(20'h00074, 0, "R9 0x34 of pair 1");
        rd(20'h00090, 0, "R9 past last pair");
        rd(20'h80010, 0, "R9 global hole");

        // R10 read data held
        rd(20'h00034, 1, "R10 latency");
        repeat (3) @(negedge clk);
        chk("R10 held", rdata, 1);

        finish_run();
    end

endmodule